// File: doc/BRIEF.md
# DSSS Transmit Preamble and Header Framer

This block produces the serial bit stream that opens a direct-sequence spread-spectrum packet. Once the host raises its transmit enable, the framer emits a long run of sync bits, a fixed 16-bit delimiter, then three header fields taken from configuration inputs (an 8-bit rate code, an 8-bit service byte and a 16-bit length), followed by a 16-bit CRC it computes over those header fields. Modulation, spreading and scrambling happen downstream and are not part of this block.

Each bit leaves on a pulse of an external bit-rate enable, so the framer runs from a fast system clock and any bit rate below it. When the last CRC bit has gone out, the framer raises a ready output. From then on it forwards one host payload bit per enable until the host drops transmit enable. Dropping transmit enable aborts the frame at any point. The configuration inputs must stay stable from the start of a frame until its last header bit.

Top module: `dsss_hdr_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ser_valid` and `tx_ready` are low.
- R2: While `tx_en` is low, `bit_en` pulses produce no output. The clock edge that first sees `tx_en` high starts a frame and emits nothing. After that, every `bit_en` pulse emits exactly one bit: `ser_valid` is high for one clock in the cycle after the pulse, with the bit on `ser_bit`.
- R3: The first 128 bits of a frame are all 1.
- R4: The next 16 bits are the delimiter word F3A0h, sent bit 0 first (0,0,0,0,0,1,0,1,1,1,0,0,1,1,1,1).
- R5: Next come `sig_field` (8 bits), then `svc_field` (8 bits, sent unchanged), then `len_field` (16 bits), each sent bit 0 first.
- R6: The next 16 bits are a CRC over the 32 header bits of R5, in the order they were sent. The register is preset to FFFFh. For each bit b, with feedback f = reg[15] xor b, the register becomes (reg << 1) xor (f ? 1021h : 0). The register is then sent inverted, register bit 15 first.
- R7: `tx_ready` is low throughout the sync, delimiter, header and CRC bits. It is high from the cycle in which the last CRC bit appears on `ser_valid` for as long as `tx_en` stays high.
- R8: While `tx_ready` is high, a `bit_en` pulse samples `pay_bit`, and that value appears on `ser_bit` with `ser_valid` in the next cycle.
- R9: When `tx_en` is low at a clock edge, no bit is emitted at that edge even if `bit_en` is high. `tx_ready` is low in the following cycle, and the next frame restarts from the first sync bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Host transmit enable; low aborts or idles the framer |
| bit_en | input | 1 | One-cycle bit-rate enable |
| sig_field | input | 8 | Rate code sent as the first header field |
| svc_field | input | 8 | Service byte sent as the second header field |
| len_field | input | 16 | Length sent as the third header field |
| pay_bit | input | 1 | Host payload bit, sampled on `bit_en` while ready |
| tx_ready | output | 1 | Header done; host supplies payload bits |
| ser_bit | output | 1 | Serial output bit |
| ser_valid | output | 1 | One-cycle strobe marking a new `ser_bit` |

## Verification
The contested cycle is the one where a bit-rate enable pulse and a drop of transmit enable land on the same clock edge. In that case the abort must win: no bit is emitted and the frame does not advance into the payload phase. The bench provokes this by pulsing `bit_en` for the final CRC bit in the very cycle it lowers `tx_en`. It then checks that the expected-bit queue still holds exactly that one CRC bit, that `tx_ready` stays low, and that the next frame starts again with sync bits.

// File: rtl/dsss_fr_pkg.sv
package dsss_fr_pkg;

  localparam int          FIELD8_W = 8;
  localparam int          LEN_W    = 16;
  localparam int          CRC_W    = 16;
  localparam int          DLM_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SYNC = 3'd1,
    PH_DLM  = 3'd2,
    PH_SIG  = 3'd3,
    PH_SVC  = 3'd4,
    PH_LEN  = 3'd5,
    PH_CRC  = 3'd6,
    PH_DATA = 3'd7
  } phase_t;

  // Order in which the frame sections follow each other.
  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_IDLE: return PH_SYNC;
      PH_SYNC: return PH_DLM;
      PH_DLM:  return PH_SIG;
      PH_SIG:  return PH_SVC;
      PH_SVC:  return PH_LEN;
      PH_LEN:  return PH_CRC;
      PH_CRC:  return PH_DATA;
      default: return PH_DATA;
    endcase
  endfunction

  // Number of bits in each counted section.
  function automatic int phase_bits(input phase_t p, input int sync_bits);
    case (p)
      PH_SYNC: return sync_bits;
      PH_DLM:  return DLM_W;
      PH_SIG:  return FIELD8_W;
      PH_SVC:  return FIELD8_W;
      PH_LEN:  return LEN_W;
      PH_CRC:  return CRC_W;
      default: return 1;
    endcase
  endfunction

  // One serial step of the header CRC.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

endpackage

// File: rtl/dsss_fr_seq.sv
module dsss_fr_seq
  import dsss_fr_pkg::*;
#(
  parameter int SYNC_BITS = 128,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             bit_en,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             emit
);

  logic sect_last;

  assign emit      = tx_en && bit_en && (phase != PH_IDLE);
  assign sect_last = (cnt == CNT_W'(phase_bits(phase, SYNC_BITS) - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_SYNC;
          cnt   <= '0;
        end
        PH_DATA: ;
        default: begin
          if (bit_en) begin
            if (sect_last) begin
              phase <= next_phase(phase);
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R5
  section_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != $past(phase)) && (phase != PH_IDLE)) |-> (phase == next_phase($past(phase))));

  // R9
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (phase == PH_IDLE));

endmodule

// File: rtl/dsss_fr_crc.sv
module dsss_fr_crc
  import dsss_fr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              emit,
  input  logic              hdr_bit,
  output logic [CRC_W-1:0]  crc_q
);

  logic crc_load;
  logic crc_upd;

  assign crc_load = (phase == PH_IDLE) || (phase == PH_SYNC);
  assign crc_upd  = emit && ((phase == PH_SIG) || (phase == PH_SVC) || (phase == PH_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n || crc_load) crc_q <= CRC_INIT;
    else if (crc_upd)       crc_q <= crc_step(crc_q, hdr_bit);
  end

  // R6
  crc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_CRC && phase == PH_CRC) |-> $stable(crc_q));

endmodule

// File: rtl/dsss_fr_bitsel.sv
module dsss_fr_bitsel
  import dsss_fr_pkg::*;
#(
  parameter logic [15:0] DLM_WORD = 16'hF3A0
) (
  input  phase_t            phase,
  input  logic [3:0]        idx,
  input  logic [7:0]        sig_field,
  input  logic [7:0]        svc_field,
  input  logic [LEN_W-1:0]  len_field,
  input  logic [CRC_W-1:0]  crc_q,
  input  logic              pay_bit,
  output logic              cur_bit
);

  always_comb begin
    case (phase)
      PH_SYNC: cur_bit = 1'b1;
      PH_DLM:  cur_bit = DLM_WORD[idx];
      PH_SIG:  cur_bit = sig_field[idx[2:0]];
      PH_SVC:  cur_bit = svc_field[idx[2:0]];
      PH_LEN:  cur_bit = len_field[idx];
      PH_CRC:  cur_bit = ~crc_q[4'd15 - idx];
      PH_DATA: cur_bit = pay_bit;
      default: cur_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsss_hdr_framer.sv
module dsss_hdr_framer
  import dsss_fr_pkg::*;
#(
  parameter int          SYNC_BITS = 128,
  parameter logic [15:0] DLM_WORD  = 16'hF3A0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        bit_en,
  input  logic [7:0]  sig_field,
  input  logic [7:0]  svc_field,
  input  logic [15:0] len_field,
  input  logic        pay_bit,
  output logic        tx_ready,
  output logic        ser_bit,
  output logic        ser_valid
);

  localparam int SYNC_CW = $clog2(SYNC_BITS);
  localparam int CNT_W   = (SYNC_CW > 4) ? SYNC_CW : 4;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic               emit;
  logic               cur_bit;
  logic [CRC_W-1:0]   crc_q;

  dsss_fr_seq #(.SYNC_BITS(SYNC_BITS), .CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .bit_en (bit_en),
    .phase  (phase),
    .cnt    (cnt),
    .emit   (emit)
  );

  dsss_fr_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .emit    (emit),
    .hdr_bit (cur_bit),
    .crc_q   (crc_q)
  );

  dsss_fr_bitsel #(.DLM_WORD(DLM_WORD)) u_sel (
    .phase     (phase),
    .idx       (cnt[3:0]),
    .sig_field (sig_field),
    .svc_field (svc_field),
    .len_field (len_field),
    .crc_q     (crc_q),
    .pay_bit   (pay_bit),
    .cur_bit   (cur_bit)
  );

  assign tx_ready = (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_valid <= 1'b0;
      ser_bit   <= 1'b0;
    end else begin
      ser_valid <= emit;
      if (emit) ser_bit <= cur_bit;
    end
  end

  // R2
  emit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> $past(bit_en && tx_en));

  // R7
  ready_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> $past(tx_en));

  // R8
  payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && bit_en && tx_en) |=> (ser_valid && ser_bit == $past(pay_bit)));

  // R9
  abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!ser_valid && !tx_ready));

endmodule

// File: tb/dsss_hdr_framer_tb.sv
module dsss_hdr_framer_tb;

  localparam int HDR_BITS = 128 + 16 + 8 + 8 + 16 + 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        bit_en = 1'b0;
  logic [7:0]  sig_field = 8'h0A;
  logic [7:0]  svc_field = 8'h00;
  logic [15:0] len_field = 16'h0000;
  logic        pay_bit = 1'b0;
  logic        tx_ready;
  logic        ser_bit;
  logic        ser_valid;

  typedef struct {
    logic  b;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #4 clk = ~clk;

  dsss_hdr_framer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .bit_en    (bit_en),
    .sig_field (sig_field),
    .svc_field (svc_field),
    .len_field (len_field),
    .pay_bit   (pay_bit),
    .tx_ready  (tx_ready),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected bit per strobe.
  always @(negedge clk) begin
    if (rst_n && ser_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected bit", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(ser_bit == e.b, e.tag, int'(ser_bit), int'(e.b));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int gap);
    bit_en = 1'b0;
    repeat (gap - 1) tick();
    bit_en = 1'b1;
    tick();
    bit_en = 1'b0;
  endtask

  function automatic logic [15:0] ref_crc(input logic [31:0] msg);
    int c = 'hFFFF;
    for (int i = 0; i < 32; i++) begin
      int top = (c >> 15) & 1;
      if ((top ^ int'(msg[i])) != 0) c = ((c << 1) ^ 'h1021) & 'hFFFF;
      else                           c = (c << 1) & 'hFFFF;
    end
    return 16'(c);
  endfunction

  task automatic push_header();
    logic [31:0] msg;
    logic [15:0] crc;
    logic [15:0] dlm = 16'hF3A0;
    exp_t e;
    msg = {len_field, svc_field, sig_field};
    crc = ref_crc(msg);
    for (int i = 0; i < 128; i++) begin e.b = 1'b1; e.tag = "R3 sync"; exp_q.push_back(e); end
    for (int i = 0; i < 16; i++)  begin e.b = dlm[i]; e.tag = "R4 delimiter"; exp_q.push_back(e); end
    for (int i = 0; i < 32; i++)  begin e.b = msg[i]; e.tag = "R5 header field"; exp_q.push_back(e); end
    for (int i = 15; i >= 0; i--) begin e.b = ~crc[i]; e.tag = "R6 crc"; exp_q.push_back(e); end
  endtask

  task automatic run_frame(input logic [7:0] s, input logic [7:0] v, input logic [15:0] l,
                           input int npay, input int gap);
    exp_t e;
    sig_field = s; svc_field = v; len_field = l;
    push_header();
    tx_en = 1'b1;
    tick();
    for (int i = 0; i < HDR_BITS; i++) begin
      if (i == HDR_BITS - 1) check(tx_ready == 1'b0, "R7 ready low in header", int'(tx_ready), 0);
      pulse(gap);
    end
    check(tx_ready == 1'b1, "R7 ready after crc", int'(tx_ready), 1);
    for (int k = 0; k < npay; k++) begin
      pay_bit = 1'($urandom);
      e.b = pay_bit; e.tag = "R8 payload"; exp_q.push_back(e);
      pulse(gap);
    end
    tick();
    check(exp_q.size() == 0, "R8 all payload out", exp_q.size(), 0);
    tx_en = 1'b0;
    tick();
    check(tx_ready == 1'b0, "R9 ready drops", int'(tx_ready), 0);
    tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 during and right after reset
    check(ser_valid == 1'b0 && tx_ready == 1'b0, "R1 reset outputs", int'({ser_valid, tx_ready}), 0);
    rst_n = 1'b1;
    tick();
    check(ser_valid == 1'b0 && tx_ready == 1'b0, "R1 after reset", int'({ser_valid, tx_ready}), 0);

    // R2 idle: enables ignored
    for (int i = 0; i < 4; i++) begin
      pulse(1);
      check(ser_valid == 1'b0, "R2 idle no output", int'(ser_valid), 0);
    end

    run_frame(8'h0A, 8'h00, 16'h0100, 20, 1);
    run_frame(8'h14, 8'h80, 16'h1234, 12, 3);
    run_frame(8'h6E, 8'h04, 16'hBEEF, 9, 2);

    // R9 abort mid-sync, then a clean restart
    sig_field = 8'h37; svc_field = 8'h00; len_field = 16'h0042;
    push_header();
    tx_en = 1'b1;
    tick();
    for (int i = 0; i < 50; i++) pulse(2);
    tick();
    tx_en = 1'b0;
    tick();
    check(tx_ready == 1'b0, "R9 ready low after abort", int'(tx_ready), 0);
    pulse(1);
    tick();
    check(exp_q.size() == HDR_BITS - 50, "R9 no bits after abort", exp_q.size(), HDR_BITS - 50);
    exp_q.delete();
    run_frame(8'h37, 8'h00, 16'h0042, 6, 1);

    // R9 abort on the same edge as the final crc bit
    sig_field = 8'hA5; svc_field = 8'h5A; len_field = 16'h00FF;
    push_header();
    tx_en = 1'b1;
    tick();
    for (int i = 0; i < HDR_BITS - 1; i++) pulse(1);
    bit_en = 1'b1;
    tx_en  = 1'b0;
    tick();
    bit_en = 1'b0;
    tick();
    tick();
    check(exp_q.size() == 1, "R9 same-edge abort drops last bit", exp_q.size(), 1);
    check(tx_ready == 1'b0, "R9 same-edge abort no ready", int'(tx_ready), 0);
    exp_q.delete();
    run_frame(8'hA5, 8'h5A, 16'h00FF, 4, 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule